// File: doc/BRIEF.md
# Cache Maintenance Controller with Invalidate Sequencer

This block is the register-facing control part of a small cache that sits in front of an external memory. A plain 32-bit register bus (address, write strobe, write data, combinational read data) reaches four locations. Two are read-only: an identification word and a size word. One is a control/status word that holds the cache enable, write-allocate and critical-word-first settings and reports a ready flag. The last is a write-only invalidate command location. The bus can take one access in every cycle.

Any write to the invalidate location starts a sweep that clears the valid bit of every cache line, one line per clock. The clears go out on a strobe-plus-index port to an external valid-bit array. While the sweep runs, the block forces the cache datapath into bypass and the ready flag reads 0. The enable bit does not have to be cleared first. A new invalidate command during a sweep restarts it from line 0. Reset clears the control bits and starts one full sweep on its own.

Top module: `cache_maint_ctrl`

## Requirements
- R1: During and after reset the control bits (enable, write-allocate, critical-word-first disable) are 0 and a sweep is running from line 0, so ready reads 0 and bypass is 1 until that sweep has cleared every line.
- R2: Address 0x000 reads the identification word: release number in bits 5:0, part number in bits 9:6, cache ID in bits 15:10, and zero in bits 31:16.
- R3: Address 0x004 reads the size word: cache size in bits 15:0 and memory size in bits 31:16.
- R4: A write to 0x100 loads bit 0 (cache enable), bit 1 (write-allocate enable) and bit 2 (critical-word-first disable, 1 = feature off) into the control bits, which drive cfg_enable, cfg_wr_alloc and cfg_cwf_off from the next cycle and read back in the same bit positions. All other bits of that word except bit 16 read 0.
- R5: Bit 16 of the word at 0x100 is a read-only ready flag: 1 when no sweep is running, 0 while one is running. Writing bit 16 has no effect.
- R6: A write of any data value to 0x700 starts a sweep. From the next cycle line_clr is 1 and line_clr_idx steps 0, 1, ... NUM_LINES-1, one line per cycle. Ready returns to 1 in the cycle after the last line is cleared, so it reads 0 for exactly NUM_LINES cycles.
- R7: A write to 0x700 while a sweep is running restarts the sweep: line_clr_idx is 0 in the next cycle and the full NUM_LINES-cycle sweep follows.
- R8: bypass is 1 exactly when the enable bit is 0 or a sweep is running.
- R9: Address 0x700 always reads 0, and every offset other than the four listed reads 0. Writes to 0x000, 0x004 or a reserved offset change no readable state and no output.
- R10: A sweep leaves the control bits unchanged, so the cache may stay enabled across an invalidation and runs cached again once ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe for the current access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| cfg_enable | output | 1 | Cache enable setting |
| cfg_wr_alloc | output | 1 | Write-allocate enable setting |
| cfg_cwf_off | output | 1 | Critical-word-first disable setting |
| bypass | output | 1 | Forces the datapath to go straight to memory |
| line_clr | output | 1 | Clear the valid bit of line line_clr_idx this cycle |
| line_clr_idx | output | IDX_W | Index of the line being cleared |

## Verification
The sweep is started from idle with the cache disabled and enabled, with command data of all zeros and all ones, and again part way through a running sweep. This separates a correct restart from a sweep that ignores a second command or only resets part of its state. The control word is loaded with several bit patterns, including writes during a sweep. These show that each setting lands in its own bit, that the ready flag cannot be written and that invalidation leaves the settings alone. Reads and writes to the read-only words, the invalidate location and reserved offsets check the fixed field layout and show that stray writes change nothing.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

   localparam int unsigned WORD_W = 32;

   localparam logic [11:0] OFS_ID   = 12'h000;
   localparam logic [11:0] OFS_SIZE = 12'h004;
   localparam logic [11:0] OFS_CTRL = 12'h100;
   localparam logic [11:0] OFS_INV  = 12'h700;

   localparam int unsigned BIT_EN      = 0;
   localparam int unsigned BIT_WALLOC  = 1;
   localparam int unsigned BIT_CWF_OFF = 2;
   localparam int unsigned BIT_READY   = 16;

   typedef struct packed {
      logic cwf_off;
      logic wr_alloc;
      logic enable;
   } ctrl_t;

   typedef enum logic [2:0] {
      SEL_ID,
      SEL_SIZE,
      SEL_CTRL,
      SEL_INV,
      SEL_NONE
   } sel_e;

endpackage

// File: rtl/cmc_addr_dec.sv
module cmc_addr_dec
   import cmc_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output sel_e              sel,
   output logic              ctrl_wr,
   output logic              inv_wr
);

   always_comb begin
      if (addr == ADDR_W'(OFS_ID))
         sel = SEL_ID;
      else if (addr == ADDR_W'(OFS_SIZE))
         sel = SEL_SIZE;
      else if (addr == ADDR_W'(OFS_CTRL))
         sel = SEL_CTRL;
      else if (addr == ADDR_W'(OFS_INV))
         sel = SEL_INV;
      else
         sel = SEL_NONE;
   end

   assign ctrl_wr = wr && (sel == SEL_CTRL);
   assign inv_wr  = wr && (sel == SEL_INV);

endmodule

// File: rtl/cmc_ctrl_reg.sv
module cmc_ctrl_reg
   import cmc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] wdata,
   output ctrl_t             ctrl
);

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^{wdata[WORD_W-1:BIT_CWF_OFF+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (load) begin
         ctrl.enable   <= wdata[BIT_EN];
         ctrl.wr_alloc <= wdata[BIT_WALLOC];
         ctrl.cwf_off  <= wdata[BIT_CWF_OFF];
      end
   end

endmodule

// File: rtl/cmc_inv_seq.sv
module cmc_inv_seq #(
   parameter int unsigned NUM_LINES = 256,
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic [IDX_W-1:0] idx
);

   logic at_last;

   generate
      if ((NUM_LINES & (NUM_LINES - 1)) == 0) begin : g_pow2
         assign at_last = &idx;
      end else begin : g_any
         assign at_last = (idx == IDX_W'(NUM_LINES - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy) begin
         if (at_last) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cmc_rd_mux.sv
module cmc_rd_mux
   import cmc_pkg::*;
#(
   parameter int unsigned REL_NUM    = 1,
   parameter int unsigned PART_NUM   = 2,
   parameter int unsigned CACHE_ID   = 3,
   parameter int unsigned CACHE_SIZE = 16,
   parameter int unsigned MEM_SIZE   = 1024
) (
   input  sel_e              sel,
   input  ctrl_t             ctrl,
   input  logic              ready,
   output logic [WORD_W-1:0] rdata
);

   localparam logic [WORD_W-1:0] ID_WORD =
      {16'h0000, 6'(CACHE_ID), 4'(PART_NUM), 6'(REL_NUM)};
   localparam logic [WORD_W-1:0] SIZE_WORD =
      {16'(MEM_SIZE), 16'(CACHE_SIZE)};

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_ID:   rdata = ID_WORD;
         SEL_SIZE: rdata = SIZE_WORD;
         SEL_CTRL: begin
            rdata[BIT_EN]      = ctrl.enable;
            rdata[BIT_WALLOC]  = ctrl.wr_alloc;
            rdata[BIT_CWF_OFF] = ctrl.cwf_off;
            rdata[BIT_READY]   = ready;
         end
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
   import cmc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned NUM_LINES  = 256,
   parameter int unsigned REL_NUM    = 1,
   parameter int unsigned PART_NUM   = 2,
   parameter int unsigned CACHE_ID   = 3,
   parameter int unsigned CACHE_SIZE = 16,
   parameter int unsigned MEM_SIZE   = 1024,
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              cfg_enable,
   output logic              cfg_wr_alloc,
   output logic              cfg_cwf_off,
   output logic              bypass,
   output logic              line_clr,
   output logic [IDX_W-1:0]  line_clr_idx
);

   generate
      if (NUM_LINES < 2) begin : g_bad_lines
         $error("NUM_LINES must be at least 2");
      end
      if (ADDR_W < 11) begin : g_bad_addr
         $error("ADDR_W must be at least 11 to reach every register");
      end
      if (REL_NUM > 63 || CACHE_ID > 63) begin : g_bad_id6
         $error("release number and cache ID must fit in 6 bits");
      end
      if (PART_NUM > 15) begin : g_bad_part
         $error("part number must fit in 4 bits");
      end
      if (CACHE_SIZE > 65535 || MEM_SIZE > 65535) begin : g_bad_size
         $error("size fields must fit in 16 bits");
      end
   endgenerate

   sel_e  sel;
   logic  ctrl_wr;
   logic  inv_wr;
   ctrl_t ctrl;
   logic  busy;

   cmc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr    (reg_addr),
      .wr      (reg_wr),
      .sel     (sel),
      .ctrl_wr (ctrl_wr),
      .inv_wr  (inv_wr)
   );

   cmc_ctrl_reg u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ctrl_wr),
      .wdata (reg_wdata),
      .ctrl  (ctrl)
   );

   cmc_inv_seq #(.NUM_LINES(NUM_LINES)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (inv_wr),
      .busy  (busy),
      .idx   (line_clr_idx)
   );

   cmc_rd_mux #(
      .REL_NUM    (REL_NUM),
      .PART_NUM   (PART_NUM),
      .CACHE_ID   (CACHE_ID),
      .CACHE_SIZE (CACHE_SIZE),
      .MEM_SIZE   (MEM_SIZE)
   ) u_rd (
      .sel   (sel),
      .ctrl  (ctrl),
      .ready (!busy),
      .rdata (reg_rdata)
   );

   assign cfg_enable   = ctrl.enable;
   assign cfg_wr_alloc = ctrl.wr_alloc;
   assign cfg_cwf_off  = ctrl.cwf_off;
   assign line_clr     = busy;
   assign bypass       = busy || !ctrl.enable;

endmodule

// File: rtl/cmc_chk.sv
module cmc_chk #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_LINES = 256,
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [31:0]       reg_rdata,
   input logic              cfg_enable,
   input logic              bypass,
   input logic              line_clr,
   input logic [IDX_W-1:0]  line_clr_idx
);

   logic inv_cmd;
   logic at_ctrl;
   logic at_inv;
   assign at_ctrl = (reg_addr == ADDR_W'(12'h100));
   assign at_inv  = (reg_addr == ADDR_W'(12'h700));
   assign inv_cmd = reg_wr && at_inv;

   // R6
   sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_clr && !inv_cmd && line_clr_idx != IDX_W'(NUM_LINES - 1))
      |=> (line_clr && line_clr_idx == IDX_W'($past(line_clr_idx) + 1'b1)));

   // R6
   sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_clr && !inv_cmd && line_clr_idx == IDX_W'(NUM_LINES - 1))
      |=> !line_clr);

   // R7
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_cmd |=> (line_clr && line_clr_idx == '0));

   // R8
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_clr || !cfg_enable) |-> bypass);

   // R8
   cached_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_clr && cfg_enable) |-> !bypass);

   // R5
   ready_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_ctrl |-> (reg_rdata[16] == !line_clr));

   // R9
   inv_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_inv |-> (reg_rdata == 32'h0));

   // R10
   enable_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_cmd |=> $stable(cfg_enable));

endmodule

bind cache_maint_ctrl cmc_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_LINES (NUM_LINES)
) u_cmc_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_addr     (reg_addr),
   .reg_wr       (reg_wr),
   .reg_rdata    (reg_rdata),
   .cfg_enable   (cfg_enable),
   .bypass       (bypass),
   .line_clr     (line_clr),
   .line_clr_idx (line_clr_idx)
);

// File: tb/tb_cache_maint_ctrl.sv
`timescale 1ns/1ps
module tb_cache_maint_ctrl;

   localparam int N     = 12;
   localparam int IW    = $clog2(N);
   localparam int REL   = 37;
   localparam int PART  = 9;
   localparam int CID   = 45;
   localparam int CSZ   = 16'h0020;
   localparam int MSZ   = 16'hA5C3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cfg_enable, cfg_wr_alloc, cfg_cwf_off, bypass, line_clr;
   logic [IW-1:0] line_clr_idx;

   always #5 clk = ~clk;

   cache_maint_ctrl #(
      .ADDR_W(12), .NUM_LINES(N), .REL_NUM(REL), .PART_NUM(PART),
      .CACHE_ID(CID), .CACHE_SIZE(CSZ), .MEM_SIZE(MSZ)
   ) dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cfg_enable(cfg_enable), .cfg_wr_alloc(cfg_wr_alloc),
      .cfg_cwf_off(cfg_cwf_off), .bypass(bypass),
      .line_clr(line_clr), .line_clr_idx(line_clr_idx)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference state
   bit       m_busy = 1;
   int       m_idx  = 0;
   bit [2:0] m_ctrl = '0;
   logic [31:0] last_rd;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(logic [11:0] a);
      case (a)
         12'h000: return {16'h0, 6'(CID), 4'(PART), 6'(REL)};
         12'h004: return {16'(MSZ), 16'(CSZ)};
         12'h100: return {15'h0, !m_busy, 13'h0, m_ctrl};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string rd_tag(logic [11:0] a);
      case (a)
         12'h000: return "R2 id word";
         12'h004: return "R3 size word";
         12'h100: return "R4/R5 control word";
         12'h700: return "R9 invalidate reads zero";
         default: return "R9 reserved reads zero";
      endcase
   endfunction

   // one bus cycle: drive, compare every output, then advance the model
   task automatic cyc(logic [11:0] a, logic w, logic [31:0] d);
      reg_addr = a; reg_wr = w; reg_wdata = d;
      #1;
      last_rd = reg_rdata;
      chk(rd_tag(a), reg_rdata, exp_rd(a));
      chk("R6 line_clr", {31'h0, line_clr}, {31'h0, m_busy});
      if (m_busy) chk("R6 line index", 32'(line_clr_idx), 32'(m_idx));
      chk("R8 bypass", {31'h0, bypass}, {31'h0, (m_busy || !m_ctrl[0])});
      chk("R4 cfg outputs", {29'h0, cfg_cwf_off, cfg_wr_alloc, cfg_enable},
          {29'h0, m_ctrl});
      @(posedge clk);
      if (w && a == 12'h700) begin
         m_busy = 1; m_idx = 0;
      end else if (m_busy) begin
         if (m_idx == N - 1) begin m_busy = 0; m_idx = 0; end
         else m_idx++;
      end
      if (w && a == 12'h100) m_ctrl = d[2:0];
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int zeros;
      repeat (3) @(negedge clk);
      // R1: state while reset is held
      #1;
      chk("R1 reset ready", {31'h0, reg_rdata[16]}, 32'h0);
      chk("R1 reset bypass", {31'h0, bypass}, 32'h1);
      chk("R1 reset control bits", {29'h0, cfg_cwf_off, cfg_wr_alloc, cfg_enable}, 32'h0);
      chk("R1 reset sweep index", 32'(line_clr_idx), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: automatic sweep after reset, ready low for N cycles
      zeros = 0;
      for (int i = 0; i < N + 3; i++) begin
         cyc(12'h100, 0, 0);
         if (last_rd[16] == 1'b0) zeros++;
      end
      chk("R1 post-reset sweep length", 32'(zeros), 32'(N));

      // R2 R3 R9: fixed words and reserved offsets
      cyc(12'h000, 0, 0);
      cyc(12'h004, 0, 0);
      cyc(12'h008, 0, 0);
      cyc(12'h0FC, 0, 0);
      cyc(12'h104, 0, 0);
      cyc(12'h700, 0, 0);
      cyc(12'h704, 0, 0);

      // R9: writes to read-only and reserved offsets change nothing
      cyc(12'h000, 1, 32'hFFFF_FFFF);
      cyc(12'h004, 1, 32'h0);
      cyc(12'h0FC, 1, 32'hFFFF_FFFF);
      cyc(12'h6FC, 1, 32'hFFFF_FFFF);
      cyc(12'h000, 0, 0);
      cyc(12'h004, 0, 0);
      cyc(12'h100, 0, 0);

      // R4 R5: control patterns, ready bit not writable
      cyc(12'h100, 1, 32'h0000_0002);
      cyc(12'h100, 0, 0);
      cyc(12'h100, 1, 32'h0000_0004);
      cyc(12'h100, 0, 0);
      cyc(12'h100, 1, 32'hFFFE_FFF9);
      cyc(12'h100, 0, 0);
      chk("R5 ready unaffected by write", {31'h0, last_rd[16]}, 32'h1);
      cyc(12'h100, 1, 32'h0000_0007);
      cyc(12'h100, 0, 0);
      chk("R8 enabled idle not bypassed", {31'h0, bypass}, 32'h0);

      // R6 R10: invalidate with cache enabled, data all ones
      cyc(12'h700, 1, 32'hFFFF_FFFF);
      zeros = 0;
      for (int i = 0; i < N + 2; i++) begin
         cyc(12'h100, 0, 0);
         if (last_rd[16] == 1'b0) zeros++;
      end
      chk("R6 sweep length", 32'(zeros), 32'(N));
      chk("R10 enable kept", {29'h0, last_rd[2:0]}, 32'h7);

      // R7: restart mid-sweep with data zero, then ctrl write during sweep
      cyc(12'h700, 1, 32'h0);
      for (int i = 0; i < N / 2; i++) cyc(12'h004, 0, 0);
      cyc(12'h700, 1, 32'h0);
      cyc(12'h100, 1, 32'h0000_0001);
      zeros = 1;
      for (int i = 0; i < N + 2; i++) begin
         cyc(12'h100, 0, 0);
         if (last_rd[16] == 1'b0) zeros++;
      end
      chk("R7 restarted sweep length", 32'(zeros), 32'(N));

      // R7: back-to-back commands
      cyc(12'h700, 1, 32'h1234_5678);
      cyc(12'h700, 1, 32'h0);
      cyc(12'h700, 1, 32'h0);
      for (int i = 0; i < N + 2; i++) cyc(12'h700, 0, 0);

      // R8: disabled cache idles in bypass
      cyc(12'h100, 1, 32'h0000_0006);
      cyc(12'h100, 0, 0);
      chk("R8 disabled bypass", {31'h0, bypass}, 32'h1);
      cyc(12'h700, 1, 32'h0);
      for (int i = 0; i < N + 2; i++) cyc(12'h000, 0, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule